// File: doc/BRIEF.md
# Parallel Memory Bus to SPI Bridge

This block lets a processor reach a memory-mapped device on an SPI link as if it were plain static RAM. The host side has a 22-bit byte address, an 8-bit write data bus, an 8-bit read data bus, three one-cycle request strobes (read, write, command write) and a ready flag. Each request the bridge accepts becomes part of an addressed SPI transaction on a single-lane master port, using SPI mode 0.

A transaction opens with chip select going low and a three-byte header. The header carries a two-bit kind code and the 22-bit address, and every field goes out most significant bit first. Reads add one dummy byte before data is taken from MISO. When a request follows the previous one at the next address and has the same kind, chip select stays low and only the new data byte is shifted. The device sees one burst of any length. When a request breaks that run, chip select goes high for one full SCLK period before a fresh header is sent. If no request arrives for a set number of clock cycles, the bridge closes the open transaction on its own.

Top module: `membus_spi_bridge`

## Requirements
- R1: After reset, spiCsN is 1, spiSclk is 0 and hostReady is 1.
- R2: A write request sends the header byte sequence {2'b10, addr[21:0]} MSB first, followed by the data byte, and the device stores that byte at that address.
- R3: A read request sends the header {2'b00, addr[21:0]}, then one dummy byte, then shifts one byte in from spiMiso MSB first. That byte appears on hostRdata when hostReady returns high, and it holds while hostReady stays high.
- R4: A command-write request sends the header {2'b01, addr[21:0]} followed by the data byte. It does not change the device's memory space.
- R5: A request of the same kind whose address is one greater than the last transferred byte is served in the open transaction. Chip select stays low and no new header is sent.
- R6: A request that changes kind or breaks the address run while chip select is low raises spiCsN for exactly SCLK_DIV clock cycles, then opens a new transaction with a new header.
- R7: With no new request, spiCsN rises IDLE_CYCLES clock cycles after hostReady returns high following a data byte.
- R8: hostReady drops in the cycle after a request is accepted and stays low until the last bit of that request's data byte has been shifted. Strobes seen while hostReady is low are ignored. If more than one strobe is high in an accepted cycle, write wins over command, and command wins over read.
- R9: spiSclk is low whenever spiCsN is high. It runs at the clock divided by SCLK_DIV, with a 50% duty cycle. MOSI changes on falling edges and MISO is sampled on rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 22 | Byte address of the request |
| hostWdata | input | 8 | Data for write and command requests |
| hostRd | input | 1 | Read request strobe, taken when hostReady is 1 |
| hostWr | input | 1 | Write request strobe, taken when hostReady is 1 |
| hostCmd | input | 1 | Command-write request strobe, taken when hostReady is 1 |
| hostRdata | output | 8 | Data of the last completed read |
| hostReady | output | 1 | High when a new request can be accepted |
| spiSclk | output | 1 | SPI serial clock, idles low |
| spiMosi | output | 1 | SPI data to the device |
| spiMiso | input | 1 | SPI data from the device |
| spiCsN | output | 1 | SPI chip select, active low |

## Verification
The bench pairs the bridge with a behavioural SPI memory and command sink, then targets how transactions are framed. It sends sequential bursts in both directions and counts chip-select frames: a bridge that does not merge would show one frame per byte. A bridge that merges too freely would place a read or a jump in address inside a write burst, and the device would store or return the wrong bytes. The bench times the chip-select gap and the idle release cycle by cycle, since an off-by-one counter shows up as a gap or timeout of the wrong length. It also drives strobes while the bridge is busy and checks that no extra transfer reaches the device.

// File: rtl/spibr_pkg.sv
package spibr_pkg;

  localparam int ADDR_W = 22;
  localparam int DATA_W = 8;
  localparam int KIND_W = 2;
  localparam int HDR_W  = ADDR_W + KIND_W;

  typedef enum logic [KIND_W-1:0] {
    KIND_READ  = 2'b00,
    KIND_CMD   = 2'b01,
    KIND_WRITE = 2'b10
  } xferKind_t;

  typedef enum logic [2:0] {
    SEL_HDR0,
    SEL_HDR1,
    SEL_HDR2,
    SEL_DUMMY,
    SEL_DATA
  } byteSel_t;

  typedef struct packed {
    logic     capture;
    logic     start;
    byteSel_t sel;
    logic     csLow;
    logic     latchRd;
    logic     bumpAddr;
  } ctrlStrobe_t;

endpackage

// File: rtl/spibr_datapath.sv
module spibr_datapath
  import spibr_pkg::*;
#(
  parameter int SCLK_DIV    = 4,
  parameter int IDLE_CYCLES = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  xferKind_t         hostKind,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              spiMiso,
  output logic              spiSclk,
  output logic              spiMosi,
  output logic              spiCsN,
  output logic [DATA_W-1:0] hostRdata,
  output logic              byteDone,
  output logic              busy,
  output logic              sameStream,
  output logic              reqIsRead
);

  localparam int HALF   = SCLK_DIV / 2;
  localparam int PH_W   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int CSH_W  = $clog2(SCLK_DIV + 1) + 1;
  localparam int IDL_W  = $clog2(IDLE_CYCLES + 3) + 1;

  xferKind_t         reqKind;
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqData;
  xferKind_t         streamKind;
  logic [ADDR_W-1:0] nextAddr;

  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [BIT_W-1:0]  bitCnt;
  logic [PH_W-1:0]   phaseCnt;
  logic              sclkR;
  logic              activeR;
  logic              csNR;
  logic [DATA_W-1:0] rdataR;
  logic [DATA_W-1:0] txByte;
  logic [HDR_W-1:0]  hdrWord;
  logic              phaseEnd;
  logic              lastBit;

  assign hdrWord  = {reqKind, reqAddr};
  assign phaseEnd = (phaseCnt == PH_W'(HALF - 1));
  assign lastBit  = (bitCnt == BIT_W'(DATA_W - 1));

  always_comb begin
    unique case (strb.sel)
      SEL_HDR0:  txByte = hdrWord[HDR_W-1 -: DATA_W];
      SEL_HDR1:  txByte = hdrWord[HDR_W-1-DATA_W -: DATA_W];
      SEL_HDR2:  txByte = hdrWord[DATA_W-1:0];
      SEL_DUMMY: txByte = '0;
      SEL_DATA:  txByte = (reqKind == KIND_READ) ? '0 : reqData;
      default:   txByte = '0;
    endcase
  end

  // request latch and stream tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqKind    <= KIND_READ;
      reqAddr    <= '0;
      reqData    <= '0;
      streamKind <= KIND_READ;
      nextAddr   <= '0;
    end else begin
      if (strb.capture) begin
        reqKind <= hostKind;
        reqAddr <= hostAddr;
        reqData <= hostWdata;
      end
      if (strb.bumpAddr) begin
        nextAddr   <= reqAddr + 1'b1;
        streamKind <= reqKind;
      end
    end
  end

  assign sameStream = (reqKind == streamKind) && (reqAddr == nextAddr);
  assign reqIsRead  = (reqKind == KIND_READ);

  // byte shift engine, mode 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift  <= '0;
      rxShift  <= '0;
      bitCnt   <= '0;
      phaseCnt <= '0;
      sclkR    <= 1'b0;
      activeR  <= 1'b0;
    end else if (strb.start) begin
      txShift  <= txByte;
      bitCnt   <= '0;
      phaseCnt <= '0;
      sclkR    <= 1'b0;
      activeR  <= 1'b1;
    end else if (activeR) begin
      if (phaseEnd) begin
        phaseCnt <= '0;
        if (!sclkR) begin
          sclkR   <= 1'b1;
          rxShift <= {rxShift[DATA_W-2:0], spiMiso};
        end else begin
          sclkR <= 1'b0;
          if (lastBit) begin
            activeR <= 1'b0;
          end else begin
            bitCnt  <= bitCnt + 1'b1;
            txShift <= {txShift[DATA_W-2:0], 1'b0};
          end
        end
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end

  assign byteDone = activeR && sclkR && phaseEnd && lastBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csNR   <= 1'b1;
      rdataR <= '0;
    end else begin
      csNR <= !strb.csLow;
      if (strb.latchRd && reqKind == KIND_READ) rdataR <= rxShift;
    end
  end

  assign spiSclk   = sclkR;
  assign spiMosi   = activeR ? txShift[DATA_W-1] : 1'b0;
  assign spiCsN    = csNR;
  assign hostRdata = rdataR;
  assign busy      = activeR;

  // checker counters
  logic [CSH_W-1:0] csHighCnt;
  logic [IDL_W-1:0] idleLowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csHighCnt  <= CSH_W'(SCLK_DIV);
      idleLowCnt <= '0;
    end else begin
      if (!csNR) csHighCnt <= '0;
      else if (csHighCnt < CSH_W'(SCLK_DIV)) csHighCnt <= csHighCnt + 1'b1;
      if (!csNR && !activeR) begin
        if (idleLowCnt < IDL_W'(IDLE_CYCLES + 2)) idleLowCnt <= idleLowCnt + 1'b1;
      end else begin
        idleLowCnt <= '0;
      end
    end
  end

  assert_sclk_idle_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    csNR |-> !sclkR);

  assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (csNR && strb.csLow) |-> (csHighCnt >= CSH_W'(SCLK_DIV - 1)));

  assert_idle_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    idleLowCnt <= IDL_W'(IDLE_CYCLES + 1));

endmodule

// File: rtl/spibr_ctrl.sv
module spibr_ctrl
  import spibr_pkg::*;
#(
  parameter int SCLK_DIV    = 4,
  parameter int IDLE_CYCLES = 48
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostRd,
  input  logic        hostWr,
  input  logic        hostCmd,
  input  logic        byteDone,
  input  logic        sameStream,
  input  logic        reqIsRead,
  output ctrlStrobe_t strb,
  output xferKind_t   hostKind,
  output logic        hostReady
);

  localparam int GAP_W = $clog2(SCLK_DIV + 1);
  localparam int IDC_W = $clog2(IDLE_CYCLES + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_PREP, ST_GAP, ST_HDR0, ST_HDR1, ST_HDR2,
    ST_DUMMY, ST_DATA, ST_HOLD
  } ctrlState_t;

  ctrlState_t       state, nextState;
  logic             csOn, csLowNext;
  logic             pend, pendNext;
  logic [GAP_W-1:0] gapCnt;
  logic [IDC_W-1:0] idleCnt;
  logic             accept;

  assign hostReady = (state == ST_IDLE) || (state == ST_HOLD);
  assign accept    = hostReady && (hostRd || hostWr || hostCmd);

  always_comb begin
    if (hostWr)       hostKind = KIND_WRITE;
    else if (hostCmd) hostKind = KIND_CMD;
    else              hostKind = KIND_READ;
  end

  always_comb begin
    strb      = '0;
    strb.sel  = SEL_DATA;
    csLowNext = csOn;
    pendNext  = pend;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          strb.capture = 1'b1;
          nextState    = ST_PREP;
        end
      end
      ST_PREP: begin
        if (csOn && sameStream) begin
          strb.start = 1'b1;
          strb.sel   = SEL_DATA;
          nextState  = ST_DATA;
        end else if (csOn) begin
          csLowNext = 1'b0;
          pendNext  = 1'b1;
          nextState = ST_GAP;
        end else begin
          strb.start = 1'b1;
          strb.sel   = SEL_HDR0;
          csLowNext  = 1'b1;
          nextState  = ST_HDR0;
        end
      end
      ST_GAP: begin
        if (gapCnt == GAP_W'(SCLK_DIV - 1)) begin
          if (pend) begin
            strb.start = 1'b1;
            strb.sel   = SEL_HDR0;
            csLowNext  = 1'b1;
            pendNext   = 1'b0;
            nextState  = ST_HDR0;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      ST_HDR0: begin
        if (byteDone) begin
          strb.start = 1'b1;
          strb.sel   = SEL_HDR1;
          nextState  = ST_HDR1;
        end
      end
      ST_HDR1: begin
        if (byteDone) begin
          strb.start = 1'b1;
          strb.sel   = SEL_HDR2;
          nextState  = ST_HDR2;
        end
      end
      ST_HDR2: begin
        if (byteDone) begin
          strb.start = 1'b1;
          if (reqIsRead) begin
            strb.sel  = SEL_DUMMY;
            nextState = ST_DUMMY;
          end else begin
            strb.sel  = SEL_DATA;
            nextState = ST_DATA;
          end
        end
      end
      ST_DUMMY: begin
        if (byteDone) begin
          strb.start = 1'b1;
          strb.sel   = SEL_DATA;
          nextState  = ST_DATA;
        end
      end
      ST_DATA: begin
        if (byteDone) begin
          strb.latchRd  = 1'b1;
          strb.bumpAddr = 1'b1;
          nextState     = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (accept) begin
          strb.capture = 1'b1;
          nextState    = ST_PREP;
        end else if (idleCnt == IDC_W'(IDLE_CYCLES - 1)) begin
          csLowNext = 1'b0;
          pendNext  = 1'b0;
          nextState = ST_GAP;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    strb.csLow = csLowNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      csOn    <= 1'b0;
      pend    <= 1'b0;
      gapCnt  <= '0;
      idleCnt <= '0;
    end else begin
      state   <= nextState;
      csOn    <= csLowNext;
      pend    <= pendNext;
      gapCnt  <= (state == ST_GAP)  ? gapCnt + 1'b1  : '0;
      idleCnt <= (state == ST_HOLD) ? idleCnt + 1'b1 : '0;
    end
  end

  assert_start_needs_idle_engine_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.start && !byteDone) |-> (state == ST_PREP || state == ST_GAP));

endmodule

// File: rtl/membus_spi_bridge.sv
module membus_spi_bridge
  import spibr_pkg::*;
#(
  parameter int SCLK_DIV    = 4,
  parameter int IDLE_CYCLES = 48
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [21:0] hostAddr,
  input  logic [7:0]  hostWdata,
  input  logic        hostRd,
  input  logic        hostWr,
  input  logic        hostCmd,
  output logic [7:0]  hostRdata,
  output logic        hostReady,
  output logic        spiSclk,
  output logic        spiMosi,
  input  logic        spiMiso,
  output logic        spiCsN
);

  ctrlStrobe_t strb;
  xferKind_t   hostKind;
  logic        byteDone;
  logic        busy;
  logic        sameStream;
  logic        reqIsRead;

  spibr_ctrl #(.SCLK_DIV(SCLK_DIV), .IDLE_CYCLES(IDLE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostRd(hostRd), .hostWr(hostWr), .hostCmd(hostCmd),
    .byteDone(byteDone), .sameStream(sameStream), .reqIsRead(reqIsRead),
    .strb(strb), .hostKind(hostKind), .hostReady(hostReady)
  );

  spibr_datapath #(.SCLK_DIV(SCLK_DIV), .IDLE_CYCLES(IDLE_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostKind(hostKind),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .spiMiso(spiMiso),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiCsN(spiCsN),
    .hostRdata(hostRdata), .byteDone(byteDone), .busy(busy),
    .sameStream(sameStream), .reqIsRead(reqIsRead)
  );

  assert_accept_drops_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostReady && (hostRd || hostWr || hostCmd)) |=> !hostReady);

  assert_ready_low_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !hostReady);

  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hostReady && $past(hostReady)) |-> $stable(hostRdata));

endmodule

// File: tb/membus_spi_bridge_test.sv
`timescale 1ns/1ps
module membus_spi_bridge_test;

  localparam int DIV  = 4;
  localparam int IDLE = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [21:0] hostAddr = '0;
  logic [7:0]  hostWdata = '0;
  logic        hostRd = 1'b0, hostWr = 1'b0, hostCmd = 1'b0;
  logic [7:0]  hostRdata;
  logic        hostReady, spiSclk, spiMosi, spiCsN;
  logic        spiMiso = 1'b0;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  membus_spi_bridge #(.SCLK_DIV(DIV), .IDLE_CYCLES(IDLE)) uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRd(hostRd), .hostWr(hostWr), .hostCmd(hostCmd),
    .hostRdata(hostRdata), .hostReady(hostReady),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso), .spiCsN(spiCsN)
  );

  // behavioural SPI memory device
  logic [7:0]  mem [0:255];
  logic [7:0]  cmdLog [0:15];
  int          cmdCount = 0;
  int          frameCount = 0;
  int          riseCount = 0;
  logic [23:0] hdrShift = '0;
  logic [7:0]  byteShift = '0;
  logic [1:0]  hdrKind = 2'b11;
  logic [21:0] hdrAddr = '0;

  always @(negedge spiCsN) begin
    frameCount++;
    riseCount = 0;
  end

  always @(posedge spiSclk) if (!spiCsN) begin
    byteShift = {byteShift[6:0], spiMosi};
    if (riseCount < 24) hdrShift = {hdrShift[22:0], spiMosi};
    riseCount++;
    if (riseCount == 24) begin
      hdrKind = hdrShift[23:22];
      hdrAddr = hdrShift[21:0];
    end else if (riseCount > 24 && riseCount % 8 == 0) begin
      if (hdrKind == 2'b10)
        mem[8'(hdrAddr + 22'((riseCount - 32) / 8))] = byteShift;
      else if (hdrKind == 2'b01 && cmdCount < 16) begin
        cmdLog[cmdCount] = byteShift;
        cmdCount++;
      end
    end
  end

  always @(negedge spiSclk) if (!spiCsN) begin
    if (hdrKind == 2'b00 && riseCount >= 32)
      spiMiso = mem[8'(hdrAddr + 22'((riseCount - 32) / 8))][7 - (riseCount % 8)];
    else
      spiMiso = 1'b0;
  end

  // link observers
  int csHighRun = 0;
  int lastGap = 0;
  int sclkLowViol = 0;
  int cycle = 0;
  int lastRise = -1;
  int minPeriod = 1000;
  int highRun = 0, lowRun = 0, dutyViol = 0;

  always @(negedge clk) begin
    cycle++;
    if (spiCsN) csHighRun++;
    else begin
      if (csHighRun != 0) lastGap = csHighRun;
      csHighRun = 0;
    end
    if (spiCsN && spiSclk) sclkLowViol++;
    if (spiSclk) begin
      highRun++;
      if (lowRun != 0 && lowRun < DIV/2) dutyViol++;
      lowRun = 0;
    end else begin
      if (highRun != 0 && highRun != DIV/2) dutyViol++;
      highRun = 0;
      if (!spiCsN) lowRun++;
    end
  end

  always @(posedge spiSclk) begin
    if (lastRise >= 0 && (cycle - lastRise) < minPeriod) minPeriod = cycle - lastRise;
    lastRise = cycle;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitReady();
    do @(negedge clk); while (!hostReady);
  endtask

  task automatic issue(input int kind, input logic [21:0] a, input logic [7:0] d);
    waitReady();
    hostAddr = a; hostWdata = d;
    hostWr = (kind == 2); hostCmd = (kind == 1); hostRd = (kind == 0);
    @(negedge clk);
    hostWr = 0; hostCmd = 0; hostRd = 0;
    waitReady();
  endtask

  task automatic waitFrameEnd();
    while (!spiCsN) @(negedge clk);
    repeat (DIV + 2) @(negedge clk);
  endtask

  function automatic logic [7:0] initVal(input int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic t_reset();
    check(spiCsN == 1'b1, "R1", "csN after reset", spiCsN, 1);
    check(spiSclk == 1'b0, "R1", "sclk after reset", spiSclk, 0);
    check(hostReady == 1'b1, "R1", "ready after reset", hostReady, 1);
  endtask

  task automatic t_write_single();
    int f0 = frameCount;
    issue(2, 22'h3A5C17, 8'hA5);
    waitFrameEnd();
    check(hdrKind == 2'b10, "R2", "write header kind", hdrKind, 2);
    check(hdrAddr == 22'h3A5C17, "R2", "write header addr", hdrAddr, 22'h3A5C17);
    check(mem[8'h17] == 8'hA5, "R2", "device byte", mem[8'h17], 8'hA5);
    check(frameCount - f0 == 1, "R2", "frames", frameCount - f0, 1);
  endtask

  task automatic t_read_single();
    issue(0, 22'h2F0040, 8'h00);
    check(hostRdata == initVal(8'h40), "R3", "read data", hostRdata, initVal(8'h40));
    repeat (5) @(negedge clk);
    check(hostRdata == initVal(8'h40), "R3", "read data held", hostRdata, initVal(8'h40));
    waitFrameEnd();
    check(hdrKind == 2'b00, "R3", "read header kind", hdrKind, 0);
    check(hdrAddr == 22'h2F0040, "R3", "read header addr", hdrAddr, 22'h2F0040);
  endtask

  task automatic t_burst_write();
    int f0 = frameCount;
    for (int i = 0; i < 4; i++) issue(2, 22'h000180 + 22'(i), 8'hC0 + 8'(i));
    waitFrameEnd();
    check(frameCount - f0 == 1, "R5", "write burst frames", frameCount - f0, 1);
    for (int i = 0; i < 4; i++)
      check(mem[8'h80 + 8'(i)] == 8'hC0 + 8'(i), "R5", "burst byte", mem[8'h80 + 8'(i)], 8'hC0 + 8'(i));
  endtask

  task automatic t_burst_read();
    int f0 = frameCount;
    for (int i = 0; i < 3; i++) begin
      issue(0, 22'h0010A0 + 22'(i), 8'h00);
      check(hostRdata == initVal(8'hA0 + i), "R5", "read burst data", hostRdata, initVal(8'hA0 + i));
    end
    waitFrameEnd();
    check(frameCount - f0 == 1, "R5", "read burst frames", frameCount - f0, 1);
  endtask

  task automatic t_break_address();
    int f0 = frameCount;
    issue(2, 22'h000010, 8'h31);
    issue(2, 22'h000020, 8'h32);
    check(lastGap == DIV, "R6", "cs gap cycles", lastGap, DIV);
    waitFrameEnd();
    check(frameCount - f0 == 2, "R6", "frames on jump", frameCount - f0, 2);
    check(mem[8'h20] == 8'h32 && mem[8'h10] == 8'h31, "R6", "bytes after jump", mem[8'h20], 8'h32);
  endtask

  task automatic t_break_kind();
    int f0 = frameCount;
    issue(2, 22'h000030, 8'h77);
    issue(0, 22'h000031, 8'h00);
    check(hostRdata == initVal(8'h31), "R6", "read after kind change", hostRdata, initVal(8'h31));
    check(lastGap == DIV, "R6", "cs gap on kind change", lastGap, DIV);
    waitFrameEnd();
    check(frameCount - f0 == 2, "R6", "frames on kind change", frameCount - f0, 2);
  endtask

  task automatic t_command();
    int c0 = cmdCount;
    issue(1, 22'h000090, 8'h5D);
    issue(1, 22'h000091, 8'h6E);
    waitFrameEnd();
    check(hdrKind == 2'b01, "R4", "command header kind", hdrKind, 1);
    check(cmdCount - c0 == 2, "R4", "command bytes", cmdCount - c0, 2);
    check(cmdLog[c0] == 8'h5D && cmdLog[c0 + 1] == 8'h6E, "R4", "command data", cmdLog[c0], 8'h5D);
    check(mem[8'h90] == initVal(8'h90) && mem[8'h91] == initVal(8'h91), "R4",
          "memory untouched by command", mem[8'h90], initVal(8'h90));
  endtask

  task automatic t_ready_and_ignore();
    int f0 = frameCount;
    waitReady();
    hostAddr = 22'h000050; hostWdata = 8'h11; hostWr = 1;
    @(negedge clk);
    hostWr = 0;
    check(hostReady == 1'b0, "R8", "ready after accept", hostReady, 0);
    hostAddr = 22'h000060; hostWdata = 8'hEE; hostWr = 1;
    @(negedge clk);
    hostWr = 0;
    repeat (DIV * 8) @(negedge clk);
    check(hostReady == 1'b0, "R8", "ready during header", hostReady, 0);
    waitReady();
    waitFrameEnd();
    check(mem[8'h60] == initVal(8'h60), "R8", "busy strobe ignored", mem[8'h60], initVal(8'h60));
    check(mem[8'h50] == 8'h11, "R8", "accepted byte", mem[8'h50], 8'h11);
    check(frameCount - f0 == 1, "R8", "frames with busy strobe", frameCount - f0, 1);
    // priority: write beats command beats read
    waitReady();
    hostAddr = 22'h000070; hostWdata = 8'h4B; hostWr = 1; hostCmd = 1; hostRd = 1;
    @(negedge clk);
    hostWr = 0; hostCmd = 0; hostRd = 0;
    waitReady();
    waitFrameEnd();
    check(hdrKind == 2'b10 && mem[8'h70] == 8'h4B, "R8", "strobe priority", hdrKind, 2);
  endtask

  task automatic t_idle_timeout();
    int n = 0;
    issue(2, 22'h0000B0, 8'h22);
    while (!spiCsN) begin
      n++;
      @(negedge clk);
    end
    check(n == IDLE, "R7", "idle release cycles", n, IDLE);
    waitFrameEnd();
  endtask

  task automatic t_clocking();
    check(sclkLowViol == 0, "R9", "sclk high with cs high", sclkLowViol, 0);
    check(minPeriod == DIV, "R9", "sclk period", minPeriod, DIV);
    check(dutyViol == 0, "R9", "sclk duty", dutyViol, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = initVal(i);
    for (int i = 0; i < 16; i++) cmdLog[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_write_single();
    t_read_single();
    t_burst_write();
    t_burst_read();
    t_break_address();
    t_break_kind();
    t_command();
    t_ready_and_ignore();
    t_idle_timeout();
    t_clocking();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule